// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the word a NOR-style flash device places on its data bus while an internal program or erase runs, is suspended, or has failed. It holds the operating mode, the set of sectors chosen for the current erase, and two pulse counters: one for the running program and one for the erase, which keeps its count while the erase is suspended. Command decoding is done elsewhere, and it hands this block single-cycle command pulses. The array contents arrive on an input port. Each read strobe loads the output register either with that array word or with a status word. In the status word two toggle bits flip from read to read according to the mode and the sector addressed, and a timeout bit marks a failed operation.

The mode machine has eight states. READ is normal reading. PROG and ERASE are active operations. SUSP is erase-suspend reading. SUSP_PROG is a program issued inside a suspend. FAIL_PROG, FAIL_ERASE and FAIL_SUSP are the timeout states.

The transitions are:
- READ goes to PROG on a program command, which takes priority, or to ERASE on an erase command.
- PROG returns to READ when it completes, or goes to FAIL_PROG on timeout.
- ERASE returns to READ when it completes, goes to FAIL_ERASE on timeout, or goes to SUSP on a suspend command.
- SUSP goes to ERASE on resume, which takes priority, or to SUSP_PROG on a program command.
- SUSP_PROG returns to SUSP when it completes, or goes to FAIL_SUSP on timeout.
- FAIL_PROG and FAIL_ERASE go to READ on a reset command. FAIL_SUSP goes to SUSP on a reset command.

A command that is not listed for the current state is ignored. A program counts as completing only if it turns no 0 bit into a 1.

Top module: `flash_busy_status`

## Requirements
- R1: While reset is asserted, dq is 0x00. After reset the mode is READ. A read strobe in READ loads dq with arr_data at the next clock edge. dq changes only on the clock edge that follows a read strobe.
- R2: In PROG, each status read inverts dq[6] relative to the previous status read, leaves dq[2] unchanged, and returns 0 on dq[7], dq[4], dq[3], dq[1] and dq[0], and 0 on dq[5].
- R3: A program that sets no bit where cell_data holds 0 stays in PROG for exactly PROG_PULSES clock edges after the command edge. The next read returns array data.
- R4: In ERASE, a read of a sector whose bit was set in erase_mask at the erase command inverts both dq[6] and dq[2].
- R5: In ERASE, a read of a sector that was not selected inverts dq[6] and leaves dq[2] unchanged.
- R6: In SUSP, a read of a selected sector inverts dq[2] and leaves dq[6] unchanged. A read of an unselected sector returns arr_data.
- R7: In SUSP_PROG, each read inverts dq[6] and returns dq[2] = 0. When the program completes, the mode is SUSP again.
- R8: The erase counts only clock edges spent in ERASE, so a suspend pauses it. The erase completes once ERASE_PULSES such edges have passed. Completion clears the selected-sector set and returns the mode to READ.
- R9: A program that tries to set a bit where cell_data is 0 never completes. After PULSE_LIMIT edges, reads show dq[5] = 1 while dq[6] keeps inverting.
- R10: A reset command in FAIL_PROG or FAIL_ERASE returns the mode to READ. In FAIL_SUSP it returns the mode to SUSP with the selected sectors kept.
- R11: A command not accepted by the current state is ignored, including a reset command or an erase command during PROG and an erase command in a FAIL state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_prog | input | 1 | Program command pulse |
| cmd_erase | input | 1 | Erase command pulse |
| cmd_suspend | input | 1 | Erase-suspend command pulse |
| cmd_resume | input | 1 | Erase-resume command pulse |
| cmd_reset | input | 1 | Reset command pulse (leaves a timeout state) |
| prog_data | input | 8 | Word being programmed, sampled with cmd_prog |
| cell_data | input | 8 | Current cell contents, sampled with cmd_prog |
| erase_mask | input | NUM_SECTORS | Sectors chosen for erase, sampled with cmd_erase |
| rd_en | input | 1 | Read strobe |
| rd_sector | input | SEC_W | Sector addressed by the read |
| arr_data | input | 8 | Array word for the addressed location |
| dq | output | 8 | Registered read result |

## Verification
A wrong internal state shows up at dq on the first read after it arises. A wrong mode returns array data where a status word is due, or the reverse. A wrong toggle register shows as a dq[6] or dq[2] value that differs from the reference model on that same read. A counter error shows as a mode change one or more edges early or late, so the bench reads continuously across each completion and timeout boundary and counts the exact number of status reads. A lost sector mask or a suspended erase count that drifts shows as an array-versus-status mismatch on the first read after resume or after reset from FAIL_SUSP.

// File: rtl/flash_busy_pkg.sv
package flash_busy_pkg;

    typedef enum logic [2:0] {
        M_READ,
        M_PROG,
        M_ERASE,
        M_SUSP,
        M_SUSP_PROG,
        M_FAIL_PROG,
        M_FAIL_ERASE,
        M_FAIL_SUSP
    } fb_mode_e;

    localparam int unsigned BIT_TGL_A = 6;  // toggles on program and erase
    localparam int unsigned BIT_TMO   = 5;  // timeout flag
    localparam int unsigned BIT_TGL_B = 2;  // sector-selective toggle

    function automatic logic is_fail(input fb_mode_e m);
        return (m == M_FAIL_PROG) || (m == M_FAIL_ERASE) || (m == M_FAIL_SUSP);
    endfunction

endpackage

// File: rtl/flash_busy_pulse_ctr.sv
module flash_busy_pulse_ctr #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (en)  count <= count + 1'b1;
    end
endmodule

// File: rtl/flash_busy_mode_fsm.sv
module flash_busy_mode_fsm
    import flash_busy_pkg::*;
#(
    parameter int unsigned NUM_SECTORS  = 8,
    parameter int unsigned PROG_PULSES  = 5,
    parameter int unsigned ERASE_PULSES = 24,
    parameter int unsigned PULSE_LIMIT  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_prog,
    input  logic                   cmd_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_resume,
    input  logic                   cmd_reset,
    input  logic [7:0]             prog_data,
    input  logic [7:0]             cell_data,
    input  logic [NUM_SECTORS-1:0] erase_mask,
    output fb_mode_e               mode,
    output logic [NUM_SECTORS-1:0] sel_mask
);
    localparam int unsigned CW = $clog2(PULSE_LIMIT + ERASE_PULSES + PROG_PULSES + 1);

    fb_mode_e        mode_q, mode_d;
    logic [CW-1:0]   pcnt, ecnt;
    logic            p_clr, p_en, e_clr, e_en;
    logic            prog_ok_q;
    logic            p_done, p_tmo, e_done, e_tmo;

    flash_busy_pulse_ctr #(.WIDTH(CW)) u_prog_ctr (
        .clk(clk), .rst_n(rst_n), .clr(p_clr), .en(p_en), .count(pcnt)
    );

    flash_busy_pulse_ctr #(.WIDTH(CW)) u_erase_ctr (
        .clk(clk), .rst_n(rst_n), .clr(e_clr), .en(e_en), .count(ecnt)
    );

    assign p_done = prog_ok_q && (pcnt == CW'(PROG_PULSES - 1));
    assign p_tmo  = (pcnt == CW'(PULSE_LIMIT - 1));
    assign e_done = (ecnt == CW'(ERASE_PULSES - 1));
    assign e_tmo  = (ecnt == CW'(PULSE_LIMIT - 1));

    // next-state and counter control
    always_comb begin
        mode_d = mode_q;
        p_clr  = 1'b0;
        p_en   = 1'b0;
        e_clr  = 1'b0;
        e_en   = 1'b0;
        unique case (mode_q)
            M_READ: begin
                if (cmd_prog) begin
                    mode_d = M_PROG;
                    p_clr  = 1'b1;
                end else if (cmd_erase) begin
                    mode_d = M_ERASE;
                    e_clr  = 1'b1;
                end
            end
            M_PROG: begin
                if (p_done)     mode_d = M_READ;
                else if (p_tmo) mode_d = M_FAIL_PROG;
                else            p_en   = 1'b1;
            end
            M_ERASE: begin
                if (e_done)           mode_d = M_READ;
                else if (e_tmo)       mode_d = M_FAIL_ERASE;
                else if (cmd_suspend) mode_d = M_SUSP;
                else                  e_en   = 1'b1;
            end
            M_SUSP: begin
                if (cmd_resume) begin
                    mode_d = M_ERASE;
                end else if (cmd_prog) begin
                    mode_d = M_SUSP_PROG;
                    p_clr  = 1'b1;
                end
            end
            M_SUSP_PROG: begin
                if (p_done)     mode_d = M_SUSP;
                else if (p_tmo) mode_d = M_FAIL_SUSP;
                else            p_en   = 1'b1;
            end
            M_FAIL_PROG, M_FAIL_ERASE: begin
                if (cmd_reset) mode_d = M_READ;
            end
            M_FAIL_SUSP: begin
                if (cmd_reset) mode_d = M_SUSP;
            end
            default: mode_d = M_READ;
        endcase
    end

    // state register and latched operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= M_READ;
            sel_mask  <= '0;
            prog_ok_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (mode_q == M_READ && mode_d == M_ERASE) sel_mask <= erase_mask;
            else if (mode_d == M_READ)                 sel_mask <= '0;
            if (p_clr) prog_ok_q <= ~|(prog_data & ~cell_data);
        end
    end

    assign mode = mode_q;

    assert_fail_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fail(mode_q) && !is_fail($past(mode_q))) |->
        ($past(mode_q) == M_PROG || $past(mode_q) == M_ERASE || $past(mode_q) == M_SUSP_PROG));

    assert_susp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SUSP && !cmd_resume && !cmd_prog) |=> (mode_q == M_SUSP));

    assert_susp_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SUSP) |=> $stable(ecnt));

    assert_fail_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_FAIL_SUSP && cmd_reset) |=> (mode_q == M_SUSP));

endmodule

// File: rtl/flash_busy_read_mux.sv
module flash_busy_read_mux
    import flash_busy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fb_mode_e   mode,
    input  logic       sel,
    input  logic       rd_en,
    input  logic [7:0] arr_data,
    output logic [7:0] dq
);
    logic       tgl_a, tgl_b;
    logic       show_arr, flip_a, flip_b, hide_b;
    logic [7:0] status;

    // per-mode decision: array or status, and which toggles advance
    always_comb begin
        show_arr = 1'b0;
        flip_a   = 1'b0;
        flip_b   = 1'b0;
        hide_b   = 1'b0;
        unique case (mode)
            M_READ:                    show_arr = 1'b1;
            M_PROG, M_FAIL_PROG:       flip_a   = 1'b1;
            M_ERASE, M_FAIL_ERASE: begin
                flip_a = 1'b1;
                flip_b = sel;
            end
            M_SUSP: begin
                if (sel) flip_b   = 1'b1;
                else     show_arr = 1'b1;
            end
            M_SUSP_PROG, M_FAIL_SUSP: begin
                flip_a = 1'b1;
                hide_b = 1'b1;
            end
            default:                   show_arr = 1'b1;
        endcase
        status            = '0;
        status[BIT_TGL_A] = tgl_a;
        status[BIT_TMO]   = is_fail(mode);
        status[BIT_TGL_B] = hide_b ? 1'b0 : tgl_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq    <= '0;
            tgl_a <= 1'b0;
            tgl_b <= 1'b0;
        end else if (rd_en) begin
            dq    <= show_arr ? arr_data : status;
            tgl_a <= tgl_a ^ flip_a;
            tgl_b <= tgl_b ^ flip_b;
        end
    end

    assert_dq_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dq));

    assert_status_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode != M_READ && !(mode == M_SUSP && !sel)) |=> ((dq & 8'h9B) == 8'h00));

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
    import flash_busy_pkg::*;
#(
    parameter int unsigned NUM_SECTORS  = 8,
    parameter int unsigned PROG_PULSES  = 5,
    parameter int unsigned ERASE_PULSES = 24,
    parameter int unsigned PULSE_LIMIT  = 32,
    localparam int unsigned SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_prog,
    input  logic                   cmd_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_resume,
    input  logic                   cmd_reset,
    input  logic [7:0]             prog_data,
    input  logic [7:0]             cell_data,
    input  logic [NUM_SECTORS-1:0] erase_mask,
    input  logic                   rd_en,
    input  logic [SEC_W-1:0]       rd_sector,
    input  logic [7:0]             arr_data,
    output logic [7:0]             dq
);
    fb_mode_e               mode;
    logic [NUM_SECTORS-1:0] sel_mask;
    logic                   sel;

    flash_busy_mode_fsm #(
        .NUM_SECTORS (NUM_SECTORS),
        .PROG_PULSES (PROG_PULSES),
        .ERASE_PULSES(ERASE_PULSES),
        .PULSE_LIMIT (PULSE_LIMIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_prog   (cmd_prog),
        .cmd_erase  (cmd_erase),
        .cmd_suspend(cmd_suspend),
        .cmd_resume (cmd_resume),
        .cmd_reset  (cmd_reset),
        .prog_data  (prog_data),
        .cell_data  (cell_data),
        .erase_mask (erase_mask),
        .mode       (mode),
        .sel_mask   (sel_mask)
    );

    always_comb begin
        sel = 1'b0;
        if (int'(rd_sector) < int'(NUM_SECTORS)) sel = sel_mask[rd_sector];
    end

    flash_busy_read_mux u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .sel     (sel),
        .rd_en   (rd_en),
        .arr_data(arr_data),
        .dq      (dq)
    );

endmodule

// File: tb/flash_busy_status_bench.sv
module flash_busy_status_bench;
    localparam int NS = 8, PP = 5, EP = 24, PL = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst_n, cmd_prog, cmd_erase, cmd_suspend, cmd_resume, cmd_reset, rd_en;
    logic [7:0] prog_data, cell_data, arr_data, dq;
    logic [NS-1:0] erase_mask;
    logic [2:0] rd_sector;

    flash_busy_status #(.NUM_SECTORS(NS), .PROG_PULSES(PP), .ERASE_PULSES(EP), .PULSE_LIMIT(PL))
    u_flash_busy_status (
        .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .prog_data(prog_data), .cell_data(cell_data), .erase_mask(erase_mask),
        .rd_en(rd_en), .rd_sector(rd_sector), .arr_data(arr_data), .dq(dq)
    );

    int    checks = 0, errors = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // behavioural reference model: 0 read,1 prog,2 erase,3 susp,4 susp-prog,5/6/7 fail
    int         m_mode, m_cnt, m_ecnt;
    bit         m_ok, m_t6, m_t2;
    logic [7:0] m_mask, m_dq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_ecnt = 0; m_ok = 0;
            m_t6 = 0; m_t2 = 0; m_mask = '0; m_dq = '0;
        end else begin
            if (rd_en) begin
                bit s;
                s = m_mask[rd_sector];
                if (m_mode == 0 || (m_mode == 3 && !s)) begin
                    m_dq = arr_data;
                end else begin
                    m_dq = '0;
                    m_dq[6] = m_t6;
                    m_dq[5] = (m_mode >= 5);
                    m_dq[2] = (m_mode == 4 || m_mode == 7) ? 1'b0 : m_t2;
                    if (m_mode != 3) m_t6 = !m_t6;
                    if ((m_mode == 2 || m_mode == 6 || m_mode == 3) && s) m_t2 = !m_t2;
                end
            end
            case (m_mode)
                0: if (cmd_prog) begin
                       m_mode = 1; m_cnt = 0; m_ok = ((prog_data & ~cell_data) == 0);
                   end else if (cmd_erase) begin
                       m_mode = 2; m_ecnt = 0; m_mask = erase_mask;
                   end
                1, 4: if (m_ok && m_cnt == PP-1) m_mode = (m_mode == 1) ? 0 : 3;
                      else if (m_cnt == PL-1)    m_mode = (m_mode == 1) ? 5 : 7;
                      else m_cnt++;
                2: if (m_ecnt == EP-1) begin m_mode = 0; m_mask = '0; end
                   else if (m_ecnt == PL-1) m_mode = 6;
                   else if (cmd_suspend) m_mode = 3;
                   else m_ecnt++;
                3: if (cmd_resume) m_mode = 2;
                   else if (cmd_prog) begin
                       m_mode = 4; m_cnt = 0; m_ok = ((prog_data & ~cell_data) == 0);
                   end
                5: if (cmd_reset) m_mode = 0;
                6: if (cmd_reset) begin m_mode = 0; m_mask = '0; end
                7: if (cmd_reset) m_mode = 3;
                default: m_mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dq !== m_dq) begin
                errors++;
                $display("FAIL %s model compare at %0t: got %h expected %h", phase, $time, dq, m_dq);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input int sec, input logic [7:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_sector = sec[2:0]; arr_data = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = dq;
    endtask

    // bits: 0 prog, 1 erase, 2 suspend, 3 resume, 4 reset
    task automatic pulse(input logic [4:0] c);
        cmd_prog = c[0]; cmd_erase = c[1]; cmd_suspend = c[2]; cmd_resume = c[3]; cmd_reset = c[4];
        @(negedge clk);
        cmd_prog = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0; cmd_reset = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [7:0] v1, v2, v3;

    initial begin
        rst_n = 0; rd_en = 0; rd_sector = 0; arr_data = 0; prog_data = 0; cell_data = 0;
        erase_mask = 0; cmd_prog = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0; cmd_reset = 0;
        repeat (3) @(negedge clk);
        chk(dq == 8'h00, "R1 reset value", dq, 8'h00);
        rst_n = 1;
        @(negedge clk);
        rd(0, 8'hA5, v1);
        chk(v1 == 8'hA5, "R1 idle read", v1, 8'hA5);

        phase = "R2";
        prog_data = 8'h0F; cell_data = 8'hFF;
        pulse(5'b00001);
        rd(3, 8'hFF, v1);
        rd(3, 8'hFF, v2);
        chk(v1[6] != v2[6], "R2 dq6 toggles", v2, v1 ^ 8'h40);
        chk(v1[2] == v2[2], "R2 dq2 steady", v2, v1);
        chk((v1 & 8'hBB) == 0, "R2 unused bits and dq5 zero", v1, v1 & 8'h44);

        phase = "R3";
        for (int i = 3; i <= PP; i++) begin
            rd(3, 8'hFF, v1);
            chk(v1 != 8'hFF, "R3 status until completion", v1, 8'h00);
        end
        rd(3, 8'h3C, v1);
        chk(v1 == 8'h3C, "R3 array after completion", v1, 8'h3C);

        phase = "R11";
        pulse(5'b00001);
        erase_mask = 8'hFF;
        pulse(5'b10010);
        rd(1, 8'hFF, v1);
        chk(v1 != 8'hFF && v1[5] == 0, "R11 reset ignored in PROG", v1, 8'h00);
        idle(8);
        rd(1, 8'h11, v1);
        chk(v1 == 8'h11, "R11 erase ignored in PROG", v1, 8'h11);

        phase = "R4";
        erase_mask = 8'h05;
        pulse(5'b00010);
        rd(0, 8'hFF, v1);
        rd(0, 8'hFF, v2);
        chk(v1[6] != v2[6] && v1[2] != v2[2], "R4 both toggle in selected", v2, v1 ^ 8'h44);
        phase = "R5";
        rd(1, 8'hFF, v1);
        rd(1, 8'hFF, v2);
        chk(v1[6] != v2[6] && v1[2] == v2[2], "R5 dq6 only in unselected", v2, v1 ^ 8'h40);

        phase = "R6";
        pulse(5'b00100);
        rd(2, 8'hFF, v1);
        rd(2, 8'hFF, v2);
        chk(v1[6] == v2[6] && v1[2] != v2[2], "R6 dq2 only in suspend", v2, v1 ^ 8'h04);
        rd(1, 8'h5A, v1);
        chk(v1 == 8'h5A, "R6 unselected returns array", v1, 8'h5A);

        phase = "R7";
        prog_data = 8'h01; cell_data = 8'h0F;
        pulse(5'b00001);
        rd(4, 8'hFF, v1);
        rd(4, 8'hFF, v2);
        chk(v1[6] != v2[6] && v1[2] == 0 && v2[2] == 0, "R7 suspended program status", v2, v1 ^ 8'h40);
        idle(6);
        rd(1, 8'h77, v1);
        chk(v1 == 8'h77, "R7 back to suspend read (unselected)", v1, 8'h77);
        rd(0, 8'hFF, v1);
        chk(v1 != 8'hFF, "R7 back to suspend read (selected)", v1, 8'h00);

        phase = "R8";
        pulse(5'b01000);
        begin
            int n;
            n = 0;
            for (int i = 0; i < 100; i++) begin
                rd(0, 8'hFF, v1);
                if (v1 == 8'hFF) break;
                n++;
            end
            chk(n == EP - 4, "R8 erase remaining status reads", 8'(n), 8'(EP - 4));
        end
        rd(2, 8'h99, v1);
        chk(v1 == 8'h99, "R8 mask cleared after erase", v1, 8'h99);

        phase = "R9";
        prog_data = 8'hFF; cell_data = 8'h00;
        pulse(5'b00001);
        begin
            bit any5;
            any5 = 0;
            for (int i = 0; i < PL; i++) begin
                rd(5, 8'hFF, v1);
                if (v1[5]) any5 = 1;
            end
            chk(!any5, "R9 no timeout before limit", {2'b0, any5, 5'b0}, 8'h00);
        end
        rd(5, 8'hFF, v1);
        rd(5, 8'hFF, v2);
        chk(v1[5] && v2[5], "R9 dq5 after limit", v1, 8'h20);
        chk(v1[6] != v2[6], "R9 dq6 keeps toggling", v2, v1 ^ 8'h40);
        phase = "R11";
        pulse(5'b00010);
        rd(5, 8'hFF, v3);
        chk(v3[5] == 1'b1, "R11 erase ignored in fail", v3, 8'h20);
        phase = "R10";
        pulse(5'b10000);
        rd(5, 8'h42, v1);
        chk(v1 == 8'h42, "R10 reset returns to read", v1, 8'h42);

        erase_mask = 8'h80;
        pulse(5'b00010);
        pulse(5'b00100);
        pulse(5'b00001);
        for (int i = 0; i <= PL; i++) rd(7, 8'hFF, v1);
        chk(v1[5] && v1[2] == 0, "R10 fail inside suspend", v1, 8'h20);
        pulse(5'b10000);
        rd(7, 8'hFF, v1);
        chk(v1 != 8'hFF && v1[5] == 0, "R10 reset returns to suspend (selected kept)", v1, 8'h00);
        rd(3, 8'h24, v1);
        chk(v1 == 8'h24, "R10 suspend read of unselected", v1, 8'h24);
        pulse(5'b01000);
        idle(EP + 4);
        rd(7, 8'h81, v1);
        chk(v1 == 8'h81, "R8 erase finishes after resume", v1, 8'h81);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired during %s", phase);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule